// File: doc/BRIEF.md
# Serial Flash Burst Read Engine (Single and Dual Output)

This block is the host side of a serial flash read path. A single `start` pulse, a 24-bit byte address, a byte count and a mode bit are enough to fetch a burst of bytes. The engine asserts chip select and sends the read opcode and the address on the shared data line. It then runs eight dummy clocks with that line released and collects the returned bytes. Each finished byte appears on a one-cycle strobe. When the last byte is in, chip select is raised and `done` pulses.

The mode bit picks one of two read commands. The single-line fast read takes every data bit from the device output pin, so each byte costs eight serial clocks. The dual-output read samples both pins on each rising serial clock: the bidirectional line carries the odd bits of each byte and the output pin carries the even bits. A byte then completes in four serial clocks. The serial clock is derived from the system clock by a parameterised divider and idles low. The device launches data on falling edges, and the engine samples it on the next rising edge.

Top module: `spi_dual_fetch`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, the data-line output enable is low, and both `rd_valid` and `done` are low.
- R2: A transfer first sends 32 bits on the data line, most significant bit first, each valid at a rising serial clock. The first eight bits are the opcode (0x0B when `dual_mode`=0, 0x3B when `dual_mode`=1) and the next 24 are the start address.
- R3: The output enable drops on the falling serial clock that follows the 32nd rising edge. It stays low through the eight dummy clocks and the whole data phase, and it rises only together with chip select falling.
- R4: In single mode, each byte is built from eight consecutive samples of `spi_do_i`, taken on rising serial clocks after the 40-clock prefix, first sample as bit 7.
- R5: In dual mode, each byte takes four rising serial clocks. Each sample takes `spi_dio_i` as the odd bit (7, 5, 3, 1) and `spi_do_i` as the even bit (6, 4, 2, 0).
- R6: `rd_valid` pulses for one system clock per byte. A transfer yields exactly `byte_count` bytes, in order of ascending address.
- R7: A `start` with `byte_count`=0 raises `done` in the next cycle and never asserts chip select.
- R8: Chip select rises on the falling serial clock that follows the rising edge completing the last byte. `done` pulses in that same cycle, and the serial clock is low whenever chip select is high.
- R9: The serial clock period is 2*HALF_DIV system clocks. Chip select stays low for exactly 2*HALF_DIV*(40+8N) cycles in single mode and 2*HALF_DIV*(40+4N) cycles in dual mode, for N bytes.
- R10: A `start` pulse during a transfer is ignored. Address, mode and count of the running transfer are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a burst (acted on only when idle) |
| start_addr | input | 24 | First byte address |
| byte_count | input | CNT_W | Number of bytes to fetch |
| dual_mode | input | 1 | 1 selects the dual-output read |
| rd_data | output | 8 | Assembled byte |
| rd_valid | output | 1 | One-cycle strobe per byte |
| done | output | 1 | One-cycle pulse at end of burst |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_dio_o | output | 1 | Data line output value |
| spi_dio_oe | output | 1 | Data line output enable |
| spi_dio_i | input | 1 | Data line input (odd bits in dual mode) |
| spi_do_i | input | 1 | Device output pin (all bits single, even bits dual) |

## Verification
The bench targets the turnaround of the shared line. A design that releases it one clock early or late collides with the device model, which the bench detects by sampling the enable on every rising serial clock. Byte assembly in dual mode is checked with data whose odd and even bits differ. A swapped pin pair or a wrong shift distance would then return corrupted bytes rather than a lucky match. Burst length corner cases are one byte, several bytes and zero bytes; an off-by-one in the countdown shows up as an extra or missing strobe and a wrong chip-select duration. A start pulse issued in mid-transfer with a different address and mode must leave the running burst intact.

// File: rtl/spi_fetch_pkg.sv
package spi_fetch_pkg;
    localparam logic [7:0] OPC_SINGLE = 8'h0B;
    localparam logic [7:0] OPC_DUAL   = 8'h3B;
    localparam int CMD_BITS    = 8;
    localparam int ADDR_BITS   = 24;
    localparam int DUMMY_CLKS  = 8;
    localparam int TX_BITS     = CMD_BITS + ADDR_BITS;
    localparam int PREFIX_CLKS = TX_BITS + DUMMY_CLKS;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_RUN  = 2'd1,
        FS_TAIL = 2'd2
    } fetch_st_e;
endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] WRAP = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          sck_d, sck_q;
    logic          wrap;

    always_comb begin
        wrap     = run && (cnt_q == WRAP);
        rise_evt = wrap && !sck_q;
        fall_evt = wrap && sck_q;
        cnt_d    = cnt_q;
        sck_d    = sck_q;
        if (!run) begin
            cnt_d = '0;
            sck_d = 1'b0;
        end else if (wrap) begin
            cnt_d = '0;
            sck_d = !sck_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sck_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            sck_q <= sck_d;
        end
    end

    assign sck = sck_q;
endmodule

// File: rtl/spi_rx_assembler.sv
module spi_rx_assembler (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       sample,
    input  logic       dual,
    input  logic       odd_in,
    input  logic       even_in,
    output logic       byte_done,
    output logic [7:0] data,
    output logic       valid
);
    logic [7:0] sh_d, sh_q;
    logic [3:0] cnt_d, cnt_q;
    logic [3:0] cnt_next;
    logic [7:0] data_d, data_q;
    logic       valid_d, valid_q;

    always_comb begin
        sh_d     = sh_q;
        cnt_d    = cnt_q;
        data_d   = data_q;
        valid_d  = 1'b0;
        cnt_next = cnt_q + (dual ? 4'd2 : 4'd1);
        byte_done = sample && (cnt_next == 4'd8);
        if (clear) begin
            cnt_d = '0;
            sh_d  = '0;
        end else if (sample) begin
            sh_d  = dual ? {sh_q[5:0], odd_in, even_in} : {sh_q[6:0], even_in};
            cnt_d = byte_done ? 4'd0 : cnt_next;
            if (byte_done) begin
                data_d  = sh_d;
                valid_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            cnt_q   <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            sh_q    <= sh_d;
            cnt_q   <= cnt_d;
            data_q  <= data_d;
            valid_q <= valid_d;
        end
    end

    assign data  = data_q;
    assign valid = valid_q;
endmodule

// File: rtl/spi_dual_fetch.sv
module spi_dual_fetch
    import spi_fetch_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [23:0]      start_addr,
    input  logic [CNT_W-1:0] byte_count,
    input  logic             dual_mode,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             done,
    output logic             spi_cs_n,
    output logic             spi_sck,
    output logic             spi_dio_o,
    output logic             spi_dio_oe,
    input  logic             spi_dio_i,
    input  logic             spi_do_i
);
    localparam int EDGE_W = $clog2(PREFIX_CLKS + 1);
    localparam logic [EDGE_W-1:0] PREFIX_CNT = EDGE_W'(PREFIX_CLKS);
    localparam logic [EDGE_W-1:0] TX_CNT     = EDGE_W'(TX_BITS);

    typedef struct packed {
        fetch_st_e          st;
        logic [EDGE_W-1:0]  edges;
        logic [TX_BITS-1:0] tx;
        logic               oe;
        logic [CNT_W-1:0]   left;
        logic               dual;
        logic               cs_n;
        logic               done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic run, rise_evt, fall_evt, sck_w;
    logic sample_en, byte_done, clear_rx;

    spi_sck_gen #(.HALF_DIV(HALF_DIV)) u_sck (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .sck      (sck_w),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    spi_rx_assembler u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear_rx),
        .sample    (sample_en),
        .dual      (ctl_q.dual),
        .odd_in    (spi_dio_i),
        .even_in   (spi_do_i),
        .byte_done (byte_done),
        .data      (rd_data),
        .valid     (rd_valid)
    );

    always_comb begin
        run       = (ctl_q.st != FS_IDLE);
        sample_en = (ctl_q.st == FS_RUN) && rise_evt && (ctl_q.edges == PREFIX_CNT);
        clear_rx  = (ctl_q.st == FS_IDLE);
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.st)
            FS_IDLE: begin
                if (start) begin
                    if (byte_count == '0) begin
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.st    = FS_RUN;
                        ctl_d.cs_n  = 1'b0;
                        ctl_d.tx    = {(dual_mode ? OPC_DUAL : OPC_SINGLE), start_addr};
                        ctl_d.oe    = 1'b1;
                        ctl_d.edges = '0;
                        ctl_d.left  = byte_count;
                        ctl_d.dual  = dual_mode;
                    end
                end
            end
            FS_RUN: begin
                if (rise_evt && (ctl_q.edges != PREFIX_CNT)) begin
                    ctl_d.edges = ctl_q.edges + 1'b1;
                end
                if (fall_evt) begin
                    if (ctl_q.edges < TX_CNT) begin
                        ctl_d.tx = {ctl_q.tx[TX_BITS-2:0], 1'b0};
                    end else begin
                        ctl_d.oe = 1'b0;
                    end
                end
                if (byte_done) begin
                    ctl_d.left = ctl_q.left - 1'b1;
                    if (ctl_q.left == CNT_W'(1)) begin
                        ctl_d.st = FS_TAIL;
                    end
                end
            end
            FS_TAIL: begin
                if (fall_evt) begin
                    ctl_d.st   = FS_IDLE;
                    ctl_d.cs_n = 1'b1;
                    ctl_d.done = 1'b1;
                end
            end
            default: begin
                ctl_d.st   = FS_IDLE;
                ctl_d.cs_n = 1'b1;
                ctl_d.oe   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.st    <= FS_IDLE;
            ctl_q.cs_n  <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign done       = ctl_q.done;
    assign spi_cs_n   = ctl_q.cs_n;
    assign spi_sck    = sck_w;
    assign spi_dio_o  = ctl_q.tx[TX_BITS-1];
    assign spi_dio_oe = ctl_q.oe;
endmodule

// File: rtl/spi_fetch_chk.sv
module spi_fetch_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sck,
    input logic oe,
    input logic valid,
    input logic done
);
    // R8
    idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);
    // R3
    oe_only_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> !cs_n);
    // R3
    oe_rise_with_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $fell(cs_n));
    // R6
    valid_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !cs_n);
    // R8
    cs_release_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> done);
    // R7
    done_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n);
endmodule

bind spi_dual_fetch spi_fetch_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (spi_cs_n),
    .sck   (spi_sck),
    .oe    (spi_dio_oe),
    .valid (rd_valid),
    .done  (done)
);

// File: tb/sim_spi_dual_fetch.sv
module sim_spi_dual_fetch;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 2;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [23:0] start_addr = '0;
    logic [CW-1:0] byte_count = '0;
    logic dual_mode = 1'b0;
    logic [7:0] rd_data;
    logic rd_valid, done, spi_cs_n, spi_sck, spi_dio_o, spi_dio_oe;
    logic dev_dio, dev_do;

    always #(CLK_PERIOD/2) clk = !clk;

    spi_dual_fetch #(.HALF_DIV(HALF), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .byte_count(byte_count), .dual_mode(dual_mode), .rd_data(rd_data),
        .rd_valid(rd_valid), .done(done), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_dio_o(spi_dio_o), .spi_dio_oe(spi_dio_oe), .spi_dio_i(dev_dio),
        .spi_do_i(dev_do)
    );

    function automatic logic [7:0] mem_at(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ {a[3:0], a[7:4]} ^ 8'h5A;
    endfunction

    int n_chk = 0, n_fail = 0;
    int m_chk = 0, m_fail = 0;
    logic [7:0] exp_q[$];
    logic cur_dual = 1'b0;

    // device model: captures command/address, checks line ownership, returns data
    logic [7:0]  dev_opc = '0;
    logic [23:0] dev_addr = '0;
    int          oe_bad = 0;
    initial begin
        logic [31:0] cap;
        logic [23:0] da;
        int dcnt, bp;
        logic [7:0] b;
        dev_dio = 1'b0;
        dev_do  = 1'b0;
        forever begin
            @(negedge spi_cs_n);
            dcnt = 0; cap = '0; bp = 7; da = '0;
            while (spi_cs_n == 1'b0) begin
                @(posedge spi_sck or posedge spi_cs_n);
                if (spi_cs_n) break;
                if (dcnt < 32) begin
                    cap = {cap[30:0], spi_dio_o};
                    if (!spi_dio_oe) oe_bad++;
                end else if (spi_dio_oe) begin
                    oe_bad++;
                end
                dcnt++;
                if (dcnt == 32) begin
                    dev_opc  = cap[31:24];
                    dev_addr = cap[23:0];
                    da = cap[23:0];
                    bp = 7;
                end
                @(negedge spi_sck or posedge spi_cs_n);
                if (spi_cs_n) break;
                if (dcnt >= 40) begin
                    b = mem_at(da);
                    if (cap[31:24] == 8'h3B) begin
                        dev_dio = b[bp];
                        dev_do  = b[bp-1];
                        bp -= 2;
                    end else begin
                        dev_do = b[bp];
                        bp -= 1;
                    end
                    if (bp < 0) begin
                        bp = 7;
                        da = da + 24'd1;
                    end
                end
            end
            dev_dio = 1'b0;
            dev_do  = 1'b0;
        end
    end

    // monitor: pops expected bytes, measures chip-select low time
    int cs_len = 0, last_cs_len = 0;
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            m_chk++;
            if (exp_q.size() == 0) begin
                m_fail++;
                $display("FAIL R6 unexpected byte actual=%02h expected=none", rd_data);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (rd_data !== e) begin
                    m_fail++;
                    $display("FAIL %s byte actual=%02h expected=%02h",
                             cur_dual ? "R5" : "R4", rd_data, e);
                end
            end
        end
        if (!spi_cs_n) cs_len++;
        else if (cs_len != 0) begin
            last_cs_len = cs_len;
            cs_len = 0;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary(input int extra_fail);
        int tot, bad;
        tot = n_chk + m_chk + extra_fail;
        bad = n_fail + m_fail + extra_fail;
        $display("  %0d/%0d checks passed", tot - bad, tot);
    endtask

    task automatic xfer(input logic [23:0] a, input int n, input logic dm, input logic interfere);
        int oe_before, exp_len;
        oe_before = oe_bad;
        cur_dual = dm;
        for (int i = 0; i < n; i++) exp_q.push_back(mem_at(a + 24'(i)));
        @(negedge clk);
        start = 1'b1; start_addr = a; byte_count = CW'(n); dual_mode = dm;
        @(negedge clk);
        start = 1'b0; start_addr = '0; byte_count = '0; dual_mode = 1'b0;
        if (interfere) begin
            repeat (30) @(negedge clk);
            // R10: restart attempt with other address, mode and count
            start = 1'b1; start_addr = 24'h000777; byte_count = CW'(9); dual_mode = !dm;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R8 cs high sck low at done",
            {spi_cs_n, spi_sck}, 2'b10);
        @(negedge clk);
        chk(exp_q.size() == 0, "R6 all bytes received", exp_q.size(), 0);
        exp_q.delete();
        chk(dev_opc == (dm ? 8'h3B : 8'h0B), "R2 opcode", dev_opc, dm ? 8'h3B : 8'h0B);
        chk(dev_addr == a, interfere ? "R10 address kept" : "R2 address", dev_addr, a);
        chk(oe_bad == oe_before, "R3 line ownership", oe_bad - oe_before, 0);
        exp_len = 2 * HALF * (40 + n * (dm ? 4 : 8));
        chk(last_cs_len == exp_len, "R9 cs low duration", last_cs_len, exp_len);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary(1);
        $finish;
    end

    initial begin
        int pre_len;
        repeat (3) @(negedge clk);
        // R1
        chk(spi_cs_n === 1'b1 && spi_sck === 1'b0 && spi_dio_oe === 1'b0 &&
            rd_valid === 1'b0 && done === 1'b0, "R1 reset outputs",
            {spi_cs_n, spi_sck, spi_dio_oe, rd_valid, done}, 5'b10000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        xfer(24'h123456, 3, 1'b0, 1'b0);   // R4 single mode burst
        xfer(24'hABCDEF, 5, 1'b1, 1'b0);   // R5 dual mode burst
        xfer(24'h00FFFE, 1, 1'b1, 1'b0);   // R5 single byte dual
        xfer(24'h7FFFFF, 1, 1'b0, 1'b0);   // R4 single byte single
        xfer(24'h0A0B0C, 4, 1'b1, 1'b1);   // R10 start during transfer

        // R7: zero-length request
        pre_len = last_cs_len;
        @(negedge clk);
        start = 1'b1; start_addr = 24'h111111; byte_count = '0; dual_mode = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done === 1'b1, "R7 done next cycle", done, 1);
        chk(spi_cs_n === 1'b1, "R7 no chip select", spi_cs_n, 1);
        repeat (20) @(negedge clk);
        chk(cs_len == 0 && last_cs_len == pre_len && !rd_valid, "R7 bus stayed idle",
            cs_len, 0);

        summary(0);
        $finish;
    end
endmodule